// File: doc/BRIEF.md
# Serial Codeword Check-Sum Engine

This block computes and verifies the 16-bit error-check field of a 64-bit radio codeword, one bit at a time. Each codeword is framed by a one-cycle `start` pulse, which clears the engine and latches the operating mode. Bits are then offered on `bit_in`, with `bit_vld` qualifying each one, in transmission order. Idle cycles between bits are allowed.

In generate mode the engine takes a 48-bit message. It divides the message modulo-2 by x^15 + x^14 + x^13 + x^11 + x^4 + x^2 + 1, inverts the final remainder bit and adds an even-parity bit. The result is a 16-bit check word that the transmitter appends to the message.

In check mode the engine takes a whole received codeword. It returns a 15-bit syndrome, a parity-error flag and a pass flag. All results are held until the next `start`, so a host can read them late.

Top module: `cw_checksum`

## Requirements
- R1: After reset, `done`, `chk_true`, `syn_lo`, `syn_hi` and `check_word[15:1]` are all zero.
- R2: In generate mode (`mode_chk`=0 at `start`), `done` rises in the cycle after the 48th accepted bit. `check_word[15:1]` then holds the remainder of message·x^15 divided by the generator polynomial. The first bit fed is taken as the highest-order message coefficient. `check_word[15]` holds the x^14 coefficient, and `check_word[1]` holds the x^0 coefficient inverted.
- R3: In generate mode, `check_word[0]` is the even parity over the 48 message bits and `check_word[15:1]`. The XOR of all 64 codeword bits is therefore zero.
- R4: In check mode (`mode_chk`=1 at `start`), the syndrome is computed as follows. The first 63 accepted bits are divided, with the 63rd bit inverted before it enters the divider. Syndrome bit S(i+1) is the coefficient of x^i of the resulting remainder, for i = 0 to 14.
- R5: In check mode, the parity-error flag is the XOR of the first 63 accepted bits and the 64th bit. `done` rises in the cycle after the 64th accepted bit.
- R6: `chk_true` is 1 only when `done` is 1, the engine is in check mode, all syndrome bits are zero and the parity-error flag is 0.
- R7: `syn_lo[7:0]` carries S1 to S8 in bits 0 to 7. `syn_hi[6:0]` carries S9 to S15, and `syn_hi[7]` carries the parity-error flag. For an error-free codeword both bytes are zero.
- R8: `start` clears all state and restarts bit counting. A bit offered in the same cycle as `start` is dropped.
- R9: Once `done` is set, further bits are ignored and the results hold until the next `start`. Cycles with `bit_vld` low change nothing.
- R10: `mode_chk` is sampled only on `start`. Changing it during a codeword has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear engine and latch mode at a codeword boundary |
| mode_chk | input | 1 | 0 = generate, 1 = check; sampled on `start` |
| bit_vld | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial data bit, first-transmitted first |
| done | output | 1 | Results valid and held |
| check_word | output | 16 | Generate mode: modified remainder in [15:1], parity in [0] |
| syn_lo | output | 8 | S1..S8 |
| syn_hi | output | 8 | S9..S15 in [6:0], parity error in [7] |
| chk_true | output | 1 | Codeword passed both checks |

## Verification
The bench targets these corner cases and the failure each one would expose:
- All-zero message. The only non-zero check-word bits come from the inverted last remainder bit and the parity it forces. A design that skipped the inversion would return zero here.
- Valid codewords in check mode. A design that forgot to invert bit 63 before the divider would report a non-zero syndrome and reject every good codeword.
- Flipped 64th bit. This is a parity-only error: the syndrome must stay zero while the high byte shows 0x80. A design that folded parity into the divider would get this wrong.
- Start arriving together with a bit, a run abandoned halfway, bits arriving after completion, and a mode change during a codeword. A design that mishandled any of these would shift its remainder and miss every expected word.

// File: rtl/cw_checksum.sv
module cw_checksum #(
  parameter int          MSG_BITS = 48,
  parameter int          CRC_W    = 15,
  parameter logic [14:0] POLY     = 15'h6815
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mode_chk,
  input  logic        bit_vld,
  input  logic        bit_in,
  output logic        done,
  output logic [15:0] check_word,
  output logic [7:0]  syn_lo,
  output logic [7:0]  syn_hi,
  output logic        chk_true
);
  localparam int DIV_CHK = MSG_BITS + CRC_W;
  localparam int CW_BITS = DIV_CHK + 1;
  localparam int CNT_W   = $clog2(CW_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [14:0]      lfsr_q;
  logic             par_q, perr_q, mode_q, done_q;

  logic             take, in_div, fb_bit, fb, last_bit;
  logic [14:0]      rem_mod;

  assign take     = bit_vld && !start && !done_q;
  assign in_div   = mode_q ? (cnt_q < CNT_W'(DIV_CHK)) : (cnt_q < CNT_W'(MSG_BITS));
  assign fb_bit   = (mode_q && cnt_q == CNT_W'(DIV_CHK - 1)) ? ~bit_in : bit_in;
  assign fb       = fb_bit ^ lfsr_q[14];
  assign last_bit = mode_q ? (cnt_q == CNT_W'(CW_BITS - 1)) : (cnt_q == CNT_W'(MSG_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lfsr_q <= '0;
      par_q  <= 1'b0;
      perr_q <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= '0;
      lfsr_q <= '0;
      par_q  <= 1'b0;
      perr_q <= 1'b0;
      mode_q <= mode_chk;
      done_q <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (in_div) begin
        lfsr_q <= {lfsr_q[13:0], 1'b0} ^ (fb ? POLY : 15'h0);
        par_q  <= par_q ^ bit_in;
      end else begin
        perr_q <= par_q ^ bit_in;
      end
      if (last_bit) done_q <= 1'b1;
    end
  end

  assign rem_mod    = {lfsr_q[14:1], ~lfsr_q[0]};
  assign check_word = (done_q && !mode_q) ? {rem_mod, par_q ^ (^rem_mod)} : 16'h0;
  assign syn_lo     = (done_q && mode_q) ? lfsr_q[7:0] : 8'h0;
  assign syn_hi     = (done_q && mode_q) ? {perr_q, lfsr_q[14:8]} : 8'h0;
  assign chk_true   = done_q && mode_q && (syn_lo == 8'h0) && (syn_hi == 8'h0);
  assign done       = done_q;

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0 && lfsr_q == '0 && !done && !par_q && !perr_q));
  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(lfsr_q) && $stable(perr_q) && $stable(check_word)));
  p_idle_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !start) |=> ($stable(cnt_q) && $stable(lfsr_q) && $stable(par_q)));
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CW_BITS));
  p_mode_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mode_q));
  p_gen_no_perr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> (!perr_q && !chk_true));
  p_done_after_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bit_vld));
endmodule

// File: tb/cw_checksum_tb.sv
module cw_checksum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode_chk = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic        done, chk_true;
  logic [15:0] check_word;
  logic [7:0]  syn_lo, syn_hi;
  int          n_cmp = 0, n_bad = 0;
  int unsigned seed_dummy;

  always #4 clk = ~clk;

  cw_checksum dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_chk(mode_chk),
    .bit_vld(bit_vld), .bit_in(bit_in), .done(done), .check_word(check_word),
    .syn_lo(syn_lo), .syn_hi(syn_hi), .chk_true(chk_true)
  );

  function automatic logic [14:0] poly_mod(input logic [63:0] v, input int n);
    logic [15:0] r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      r = {r[14:0], v[i]};
      if (r[15]) r ^= 16'hE815;
    end
    for (int i = 0; i < 15; i++) begin
      r = {r[14:0], 1'b0};
      if (r[15]) r ^= 16'hE815;
    end
    return r[14:0];
  endfunction

  function automatic logic [15:0] exp_cw(input logic [47:0] msg);
    logic [14:0] rem, rm;
    rem = poly_mod({16'h0, msg}, 48);
    rm  = {rem[14:1], ~rem[0]};
    return {rm, (^msg) ^ (^rm)};
  endfunction

  function automatic logic [15:0] exp_syn(input logic [63:0] v);
    logic [62:0] f;
    logic [14:0] s;
    f = v[63:1] ^ 63'd1;
    s = poly_mod({1'b0, f}, 63);
    return {(^v[63:1]) ^ v[0], s};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic m, input logic with_bit);
    @(negedge clk);
    start = 1'b1; mode_chk = m; bit_vld = with_bit; bit_in = 1'b1;
    @(negedge clk);
    start = 1'b0; bit_vld = 1'b0;
  endtask

  task automatic feed(input logic [63:0] v, input int n, input logic flip_mode);
    for (int i = n - 1; i >= 0; i--) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        bit_vld = 1'b0; bit_in = $urandom_range(0, 1);
        @(negedge clk);
      end
      bit_vld = 1'b1; bit_in = v[i];
      if (flip_mode) mode_chk = ~mode_chk;
      @(negedge clk);
    end
    bit_vld = 1'b0;
  endtask

  task automatic run_gen(input logic [47:0] msg, input string tag);
    do_start(1'b0, 1'b0);
    feed({16'h0, msg}, 48, 1'b0);
    check({tag, " R2 done"}, 32'(done), 32'd1);
    check({tag, " R2/R3 check word"}, 32'(check_word), 32'(exp_cw(msg)));
  endtask

  task automatic run_chk(input logic [63:0] v, input string tag);
    logic [15:0] e;
    e = exp_syn(v);
    do_start(1'b1, 1'b0);
    feed(v, 64, 1'b0);
    check({tag, " R5 done"}, 32'(done), 32'd1);
    check({tag, " R4/R7 syn_lo"}, 32'(syn_lo), 32'(e[7:0]));
    check({tag, " R5/R7 syn_hi"}, 32'(syn_hi), 32'(e[15:8]));
    check({tag, " R6 chk_true"}, 32'(chk_true), 32'(e == 16'h0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] msg;
    logic [63:0] cw;
    seed_dummy = $urandom(32'd1327);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", 32'(done), 0);
    check("R1 chk_true", 32'(chk_true), 0);
    check("R1 syndrome", {16'h0, syn_hi, syn_lo}, 0);
    check("R1 check word", 32'(check_word[15:1]), 0);
    rst_n = 1'b1;

    // R2/R3 all-zero message: only inverted bit and its parity
    run_gen(48'h0, "zero msg");
    check("R2 zero msg literal", 32'(check_word), 32'h0003);
    run_gen(48'hFFFF_FFFF_FFFF, "ones msg");
    for (int k = 0; k < 6; k++) begin
      msg = {$urandom(), $urandom()};
      run_gen(msg, "rand gen");
      cw = {msg, check_word};
      check("R3 codeword even", 32'(^cw), 0);
    end

    // R4..R7 good codewords
    for (int k = 0; k < 6; k++) begin
      msg = {$urandom(), $urandom()};
      run_chk({msg, exp_cw(msg)}, "good cw");
    end
    // single-bit errors in divided region
    for (int k = 0; k < 5; k++) begin
      msg = {$urandom(), $urandom()};
      cw  = {msg, exp_cw(msg)};
      cw[$urandom_range(1, 63)] ^= 1'b1;
      run_chk(cw, "bit error");
      check("R6 bit error rejected", 32'(chk_true), 0);
    end
    // parity-only error
    msg = 48'h1234_5678_9ABC;
    cw  = {msg, exp_cw(msg)};
    cw[0] ^= 1'b1;
    run_chk(cw, "parity only");
    check("R7 parity-only syn_hi", 32'(syn_hi), 32'h80);
    check("R7 parity-only syn_lo", 32'(syn_lo), 0);

    // R8 start with simultaneous bit, then abandoned run restarted
    msg = 48'hA5A5_0F0F_3C3C;
    do_start(1'b0, 1'b1);
    feed({16'h0, msg}, 48, 1'b0);
    check("R8 bit at start dropped", 32'(check_word), 32'(exp_cw(msg)));
    do_start(1'b1, 1'b0);
    feed(64'hDEAD_BEEF, 20, 1'b0);
    do_start(1'b0, 1'b0);
    check("R8 cleared done", 32'(done), 0);
    feed({16'h0, msg}, 48, 1'b0);
    check("R8 restart result", 32'(check_word), 32'(exp_cw(msg)));

    // R9 extra bits after done are ignored
    feed(64'hFFFF_0000_FFFF_0000, 24, 1'b0);
    check("R9 hold after extra bits", 32'(check_word), 32'(exp_cw(msg)));
    check("R9 done held", 32'(done), 1);

    // R10 mode toggled during codeword
    msg = 48'h0BAD_CAFE_0001;
    cw  = {msg, exp_cw(msg)};
    do_start(1'b1, 1'b0);
    feed(cw, 64, 1'b1);
    check("R10 mode ignored pass", 32'(chk_true), 1);
    check("R10 mode ignored syn", {16'h0, syn_hi, syn_lo}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule